// File: doc/BRIEF.md
# Home Directory Controller

This block sits at the home node of a set of memory blocks and owns their coherence bookkeeping. Each stored word holds a block's line data together with its directory fields: a two-bit state, a sharer vector with one bit per board, and the index of the exclusive owner. These fields sit in the spare check-bit space of the same word, so one access yields both the data and the coherence state. Requests arrive one at a time from any board on a valid/ready channel. The controller then either streams the line back in two half-line beats or signals that a remote owner must be recalled first.

Reads add the requester to the sharer set. A write-ownership request makes the requester the exclusive owner and asks the former sharers to drop their copies. A write-back returns a full line and puts the block back under home ownership. The controller handles one request at a time. Backpressure holds later requests off until the current reply has left.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is in the home-only state (state code 0) with line data zero and no sharers; `req_ready` is high and `rsp_valid`, `recall_valid` and `inval_valid` are low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the edge that presents the last reply beat. It is low in the cycle after acceptance and during the first reply beat.
- R3: A read (`req_kind` 0) or ownership request (`req_kind` 1) to a block in state 0 or 1 (shared) gives a reply. `rsp_valid` is high with `rsp_last` low and the low half of the line in the second cycle after acceptance, then high with `rsp_last` high and the upper half in the next cycle. `rsp_board` carries the requester throughout.
- R4: A served read moves the block to the shared state (code 1) and sets the requester's bit (bit index = board number) in the sharer vector, keeping the bits already set.
- R5: A served ownership request moves the block to exclusive (code 2) with the requester as owner and only its sharer bit set. Together with the first reply beat, `inval_valid` pulses with `inval_mask` = previous sharers minus the requester and `inval_blk` = the block. There is no pulse when that mask is empty.
- R6: A read or ownership request to an exclusive block gives no reply. Instead `recall_valid` pulses for one cycle, in the second cycle after acceptance, with `recall_board` = current owner and `recall_blk` = the block. The directory entry is left unchanged.
- R7: A write-back (`req_kind` 2) stores `req_line` as the block's line, returns the block to state 0 and clears all sharer bits. It produces no reply, no recall and no invalidate.
- R8: A request with `req_kind` 3, or with `req_board` not below the board count, is accepted and ignored. It produces no output pulse and changes no directory entry or line data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read, 1 ownership, 2 write-back, 3 reserved |
| req_board | input | $clog2(NB) | Requesting board |
| req_blk | input | $clog2(NBLK) | Target block index |
| req_line | input | 2*BEAT_W | Line carried by a write-back |
| rsp_valid | output | 1 | Reply beat valid |
| rsp_last | output | 1 | Second (upper-half) beat |
| rsp_board | output | $clog2(NB) | Destination board of the reply |
| rsp_data | output | BEAT_W | Reply beat data |
| recall_valid | output | 1 | Exclusive owner must be recalled |
| recall_board | output | $clog2(NB) | Owner to recall |
| recall_blk | output | $clog2(NBLK) | Block to recall |
| inval_valid | output | 1 | Former sharers must invalidate |
| inval_mask | output | NB | Boards to invalidate |
| inval_blk | output | $clog2(NBLK) | Block to invalidate |

## Verification
The assertions watch the properties of each cycle. A first beat is always followed by a last beat to the same board. The ready line is low after acceptance and during the first beat. A recall never coincides with a reply. An invalidate only rides with a first beat and never names the requester. The properties that depend on history come only from the bench's scenarios, which it checks against its own directory model. These are the growth of the sharer set, the exact invalidate mask, the owner named in a recall, the write-back data returning in later replies, and ignored requests leaving every entry untouched.

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl #(
  parameter int NB     = 18,
  parameter int NBLK   = 8,
  parameter int BEAT_W = 256,
  localparam int BW    = $clog2(NB),
  localparam int AW    = $clog2(NBLK),
  localparam int LW    = 2 * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [BW-1:0]     req_board,
  input  logic [AW-1:0]     req_blk,
  input  logic [LW-1:0]     req_line,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [BW-1:0]     rsp_board,
  output logic [BEAT_W-1:0] rsp_data,
  output logic              recall_valid,
  output logic [BW-1:0]     recall_board,
  output logic [AW-1:0]     recall_blk,
  output logic              inval_valid,
  output logic [NB-1:0]     inval_mask,
  output logic [AW-1:0]     inval_blk
);
  localparam int EW = LW + BW + NB + 2;
  localparam logic [1:0] ST_HOME = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2;
  localparam logic [1:0] K_RD = 2'd0, K_OWN = 2'd1, K_WB = 2'd2;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_LOOK = 2'd1, PH_BEAT1 = 2'd2;

  logic [EW-1:0]     mem [NBLK];
  logic [1:0]        ph;
  logic [1:0]        r_kind;
  logic [BW-1:0]     r_board;
  logic [AW-1:0]     r_blk;
  logic [LW-1:0]     r_line;
  logic [BEAT_W-1:0] hi_q;

  logic [EW-1:0]  ent;
  logic [LW-1:0]  e_line;
  logic [BW-1:0]  e_own;
  logic [NB-1:0]  e_shr;
  logic [1:0]     e_st;
  logic [NB-1:0]  rbit;
  logic           ignore;

  assign ent    = mem[r_blk];
  assign e_line = ent[LW-1:0];
  assign e_own  = ent[LW+BW-1:LW];
  assign e_shr  = ent[LW+BW+NB-1:LW+BW];
  assign e_st   = ent[EW-1:EW-2];
  assign rbit   = NB'(1) << r_board;
  assign ignore = (r_kind == 2'd3) || (32'(r_board) >= NB);
  assign req_ready = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) mem[i] <= '0;
      ph           <= PH_IDLE;
      r_kind       <= '0;
      r_board      <= '0;
      r_blk        <= '0;
      r_line       <= '0;
      hi_q         <= '0;
      rsp_valid    <= 1'b0;
      rsp_last     <= 1'b0;
      rsp_board    <= '0;
      rsp_data     <= '0;
      recall_valid <= 1'b0;
      recall_board <= '0;
      recall_blk   <= '0;
      inval_valid  <= 1'b0;
      inval_mask   <= '0;
      inval_blk    <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      recall_valid <= 1'b0;
      inval_valid  <= 1'b0;
      case (ph)
        PH_IDLE: if (req_valid) begin
          r_kind  <= req_kind;
          r_board <= req_board;
          r_blk   <= req_blk;
          r_line  <= req_line;
          ph      <= PH_LOOK;
        end
        PH_LOOK: begin
          ph <= PH_IDLE;
          if (ignore) begin
          end else if (r_kind == K_WB) begin
            mem[r_blk] <= {ST_HOME, NB'(0), BW'(0), r_line};
          end else if (e_st == ST_EXC) begin
            recall_valid <= 1'b1;
            recall_board <= e_own;
            recall_blk   <= r_blk;
          end else begin
            rsp_valid <= 1'b1;
            rsp_last  <= 1'b0;
            rsp_board <= r_board;
            rsp_data  <= e_line[BEAT_W-1:0];
            hi_q      <= e_line[LW-1:BEAT_W];
            ph        <= PH_BEAT1;
            if (r_kind == K_RD) begin
              mem[r_blk] <= {ST_SHR, e_shr | rbit, e_own, e_line};
            end else begin
              mem[r_blk] <= {ST_EXC, rbit, r_board, e_line};
              if ((e_shr & ~rbit) != '0) begin
                inval_valid <= 1'b1;
                inval_mask  <= e_shr & ~rbit;
                inval_blk   <= r_blk;
              end
            end
          end
        end
        PH_BEAT1: begin
          rsp_valid <= 1'b1;
          rsp_last  <= 1'b1;
          rsp_data  <= hi_q;
          ph        <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

module home_dir_chk #(
  parameter int NB = 18,
  localparam int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_last,
  input logic [BW-1:0] rsp_board,
  input logic          recall_valid,
  input logic          inval_valid,
  input logic [NB-1:0] inval_mask
);
  p_two_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> (rsp_valid && rsp_last && $stable(rsp_board)));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_busy_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |-> !req_ready);

  p_recall_no_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recall_valid |-> !rsp_valid);

  p_inval_with_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> (rsp_valid && !rsp_last && inval_mask != '0 && !inval_mask[rsp_board]));

  p_last_has_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> $past(rsp_valid && !rsp_last));
endmodule

bind home_dir_ctrl home_dir_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_board(rsp_board),
  .recall_valid(recall_valid), .inval_valid(inval_valid), .inval_mask(inval_mask)
);

// File: tb/home_dir_ctrl_tb.sv
`timescale 1ns/1ps
module home_dir_ctrl_tb;
  localparam int NB = 18, NBLK = 4, BEAT_W = 32;
  localparam int BW = 5, AW = 2, LW = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_kind = 0;
  logic [BW-1:0] req_board = 0;
  logic [AW-1:0] req_blk = 0;
  logic [LW-1:0] req_line = 0;
  logic rsp_valid, rsp_last, recall_valid, inval_valid;
  logic [BW-1:0] rsp_board, recall_board;
  logic [BEAT_W-1:0] rsp_data;
  logic [AW-1:0] recall_blk, inval_blk;
  logic [NB-1:0] inval_mask;

  home_dir_ctrl #(.NB(NB), .NBLK(NBLK), .BEAT_W(BEAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_board(req_board), .req_blk(req_blk), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_board(rsp_board), .rsp_data(rsp_data),
    .recall_valid(recall_valid), .recall_board(recall_board), .recall_blk(recall_blk),
    .inval_valid(inval_valid), .inval_mask(inval_mask), .inval_blk(inval_blk));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [1:0]    m_st [NBLK];
  logic [NB-1:0] m_sh [NBLK];
  logic [BW-1:0] m_ow [NBLK];
  logic [LW-1:0] m_ln [NBLK];

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk(!rsp_valid, {tag, " rsp_valid"}, 64'(rsp_valid), 0);
    chk(!recall_valid, {tag, " recall_valid"}, 64'(recall_valid), 0);
    chk(!inval_valid, {tag, " inval_valid"}, 64'(inval_valid), 0);
  endtask

  task automatic xact(input logic [1:0] k, input int b, input int blk, input logic [LW-1:0] ln);
    logic ign, reply, rec, inv;
    logic [NB-1:0] bit_, mask;
    logic [LW-1:0] data;
    logic [BW-1:0] own;
    bit_ = (b < NB) ? (NB'(1) << b) : '0;
    ign = (k == 2'd3) || (b >= NB);
    reply = 0; rec = 0; inv = 0; mask = '0; data = m_ln[blk]; own = m_ow[blk];
    if (ign) begin
    end else if (k == 2'd2) begin
      m_ln[blk] = ln; m_st[blk] = 0; m_sh[blk] = '0;
    end else if (m_st[blk] == 2'd2) begin
      rec = 1;
    end else begin
      reply = 1;
      if (k == 2'd0) begin
        m_st[blk] = 1; m_sh[blk] = m_sh[blk] | bit_;
      end else begin
        mask = m_sh[blk] & ~bit_; inv = (mask != '0);
        m_st[blk] = 2; m_sh[blk] = bit_; m_ow[blk] = BW'(b);
      end
    end
    @(negedge clk);
    chk(req_ready, "R2 ready when idle", 64'(req_ready), 1);
    req_valid = 1; req_kind = k; req_board = BW'(b); req_blk = AW'(blk); req_line = ln;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 busy after accept", 64'(req_ready), 0);
    quiet("R2 no output in lookup cycle");
    @(negedge clk);
    if (ign) quiet("R8 ignored request");
    else if (k == 2'd2) quiet("R7 write-back silent");
    else if (rec) begin
      chk(recall_valid && !rsp_valid && !inval_valid, "R6 recall pulse only",
          {recall_valid, rsp_valid, inval_valid}, 3'b100);
      chk(recall_board == own, "R6 recall owner", 64'(recall_board), 64'(own));
      chk(recall_blk == AW'(blk), "R6 recall block", 64'(recall_blk), 64'(blk));
    end else begin
      chk(rsp_valid && !rsp_last, "R3 first beat", {rsp_valid, rsp_last}, 2'b10);
      chk(!req_ready, "R2 busy during first beat", 64'(req_ready), 0);
      chk(rsp_board == BW'(b), "R3 reply board", 64'(rsp_board), 64'(b));
      chk(rsp_data == data[31:0], "R3 low half", 64'(rsp_data), 64'(data[31:0]));
      chk(!recall_valid, "R6 no recall when served", 64'(recall_valid), 0);
      chk(inval_valid == inv, "R5 invalidate pulse", 64'(inval_valid), 64'(inv));
      if (inv) begin
        chk(inval_mask == mask, "R5 invalidate mask", 64'(inval_mask), 64'(mask));
        chk(inval_blk == AW'(blk), "R5 invalidate block", 64'(inval_blk), 64'(blk));
      end
      @(negedge clk);
      chk(rsp_valid && rsp_last, "R3 last beat", {rsp_valid, rsp_last}, 2'b11);
      chk(rsp_board == BW'(b), "R3 reply board held", 64'(rsp_board), 64'(b));
      chk(rsp_data == data[63:32], "R3 high half", 64'(rsp_data), 64'(data[63:32]));
      quiet_next();
    end
  endtask

  task automatic quiet_next();
    @(negedge clk);
    quiet("R3 reply ends after two beats");
  endtask

  function automatic logic [LW-1:0] pat(input int blk, input int n);
    return {32'(blk * 32'h01010101 + n), 32'(n * 32'h9e3779b9 ^ blk)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < NBLK; i++) begin
      m_st[i] = 0; m_sh[i] = '0; m_ow[i] = '0; m_ln[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", 64'(req_ready), 1);
    quiet("R1 outputs idle after reset");
    // R1: zero lines, home state; an ownership request then raises no invalidate
    for (int blk = 0; blk < NBLK; blk++) xact(2'd1, blk, blk, '0);
    for (int blk = 0; blk < NBLK; blk++) xact(2'd2, 0, blk, pat(blk, 1));
    // R3/R4: every board reads every block, sharer set grows
    for (int blk = 0; blk < NBLK; blk++)
      for (int b = 0; b < NB; b++) xact(2'd0, (b + blk) % NB, blk, '0);
    // R5: ownership invalidates all others
    for (int blk = 0; blk < NBLK; blk++) xact(2'd1, (blk * 5) % NB, blk, '0);
    // R6: read and ownership by others hit the owner
    for (int blk = 0; blk < NBLK; blk++) begin
      xact(2'd0, 7, blk, '0);
      xact(2'd1, 11, blk, '0);
    end
    // R8: reserved kind and out-of-range boards, then observe untouched state
    for (int b = NB; b < 32; b++) xact(2'd0, b, b % NBLK, '0);
    for (int b = NB; b < 32; b++) xact(2'd2, b, b % NBLK, 64'hdead_beef_0bad_f00d);
    for (int blk = 0; blk < NBLK; blk++) xact(2'd3, 2, blk, 64'h1234);
    for (int blk = 0; blk < NBLK; blk++) xact(2'd0, 9, blk, '0);
    // R7: write-back restores home state with new data
    for (int blk = 0; blk < NBLK; blk++) begin
      xact(2'd2, 4, blk, pat(blk, 2));
      xact(2'd0, 6, blk, '0);
      xact(2'd1, 6, blk, '0);
    end
    // mixed sweep
    seed = 32'h1f2e3d4c;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 1103515245 + 12345;
      xact(2'(seed >>> 8), (seed >>> 12) & 31 % 32 < 22 ? ((seed >>> 12) & 31) % 22 : 3,
           (seed >>> 20) & 3, pat(n, n + 3));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule